// File: doc/BRIEF.md
# Reprogrammable Fractional Clock Divider

This block divides a fast oscillator clock by a fractional ratio M/N. A two's complement accumulator steps once per input clock. Its sign bit is the divided output, and the same bit chooses which of two stored constants is applied on the next edge. The division ratio therefore dithers between adjacent integers. On average the output is high for exactly N of every M input cycles.

The two constants are N and the negative value N−M. They sit in registers that change only when a reprogram strobe arrives together with a legal pair (N < M). The output frequency can therefore be retuned while the clock runs, and the accumulator is not disturbed. The accumulator is one bit wider than the operands, so no legal pair can overflow it.

Top module: `frac_divider`

## Requirements
- R1: A synchronous reset clears the accumulator to zero and drives the output low. The constants return to N = RST_N and M = RST_M (defaults 1 and 2).
- R2: `divClk` equals bit WIDTH of `accum`, the two's complement sign. It changes only at rising clock edges.
- R3: On each rising edge, the accumulator changes by the sign of its value before the edge. A clear sign subtracts N. A set sign subtracts N−M, which adds M−N.
- R4: With the constants held, once the accumulator lies in [−N, M−1], every run of M consecutive cycles contains exactly N high output cycles. Directly after reset, counting starts at the first cycle.
- R5: Once inside [−N, M−1], the signed accumulator never leaves that range.
- R6: A reprogram strobe with `progN` < `progM` (both unsigned) loads N and N−M at that edge. The accumulator update at that same edge still uses the old constants. The new constants apply from the next edge.
- R7: An accepted reprogram leaves the accumulator value untouched.
- R8: A strobe with `progN` ≥ `progM` is ignored, and the old constants stay in force.
- R9: An accepted pair with N = 0 holds the output low for as long as it is in force, once the accumulator is non-negative.
- R10: Changes on `progN` and `progM` without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| progStrobe | input | 1 | Reprogram request, sampled at the rising edge |
| progN | input | WIDTH | New high-cycle count N, unsigned |
| progM | input | WIDTH | New period length M, unsigned |
| divClk | output | 1 | Divided output (accumulator sign bit) |
| accum | output | WIDTH+1 | Accumulator contents, two's complement |

## Verification
Every result comes straight from a register. A new accumulator value and output level appear one rising edge after the inputs that caused them. Reprogrammed constants first steer the accumulator at the second edge after the strobe. The bench drives inputs on the falling edge and advances its own model of the stepping rule by one edge. It then compares `accum` and `divClk` on the next falling edge, so each comparison lands exactly one edge after its stimulus. Window counts start only after a warm-up long enough to bring the accumulator into range.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadConst;  // accept the presented N/M pair this edge
    logic selWrap;    // apply the negative constant (N-M) this edge
  } fdivStrobe_t;

endpackage

// File: rtl/fdiv_ctrl.sv
`timescale 1ns/1ps
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             progStrobe,
  input  logic [WIDTH-1:0] progN,
  input  logic [WIDTH-1:0] progM,
  input  logic             accSign,
  output fdivStrobe_t      strobes
);

  logic pairLegal;

  // Only 0 <= N < M keeps the accumulator bounded (R8)
  assign pairLegal = (progN < progM);

  always_comb begin
    strobes.loadConst = progStrobe && pairLegal;
    strobes.selWrap   = accSign;
  end

endmodule

// File: rtl/fdiv_datapath.sv
`timescale 1ns/1ps
module fdiv_datapath
  import fdiv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int RST_N = 1,
  parameter int RST_M = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [WIDTH-1:0]        progN,
  input  logic [WIDTH-1:0]        progM,
  input  fdivStrobe_t             strobes,
  output logic signed [WIDTH:0]   accum,
  output logic                    accSign
);

  localparam int ACC_W = WIDTH + 1;
  localparam logic signed [ACC_W-1:0] RST_INC = ACC_W'(RST_N);
  localparam logic signed [ACC_W-1:0] RST_DEC = ACC_W'(RST_N - RST_M);

  logic signed [ACC_W-1:0] incStep;   // N
  logic signed [ACC_W-1:0] decStep;   // N - M, always negative
  logic signed [ACC_W-1:0] loadInc;
  logic signed [ACC_W-1:0] loadDec;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] accNext;

  assign loadInc = $signed({1'b0, progN});
  assign loadDec = $signed({1'b0, progN}) - $signed({1'b0, progM});

  // Constant registers (R1, R6, R8, R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      incStep <= RST_INC;
      decStep <= RST_DEC;
    end else if (strobes.loadConst) begin
      incStep <= loadInc;
      decStep <= loadDec;
    end
  end

  // Sign selects the constant, which is subtracted (R3)
  always_comb begin
    addend  = strobes.selWrap ? decStep : incStep;
    accNext = accum - addend;
  end

  // Accumulator (R1, R7)
  always_ff @(posedge clk) begin
    if (rst) accum <= '0;
    else     accum <= accNext;
  end

  assign accSign = accum[ACC_W-1];

  // R1: leaving reset, the accumulator and constants hold their reset values
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (accum == '0) && (incStep == RST_INC) && (decStep == RST_DEC));

  // R3: a clear sign with N > 0 moves the accumulator down
  p_clear_down_r3: assert property (@(posedge clk) disable iff (rst)
    (!accSign && (incStep != '0)) |=> ($signed(accum) < $signed($past(accum))));

  // R3: a set sign moves the accumulator up
  p_set_up_r3: assert property (@(posedge clk) disable iff (rst)
    accSign |=> ($signed(accum) > $signed($past(accum))));

  // R6: an accepted pair is visible in the constants after the edge
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.loadConst |=> (incStep == $past(loadInc)) && (decStep == $past(loadDec)));

  // R8, R10: without an accepted load the constants hold
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadConst |=> $stable(incStep) && $stable(decStep));

  // R8: only legal pairs ever reach the constants, so N-M stays negative
  p_dec_neg_r8: assert property (@(posedge clk) disable iff (rst)
    $signed(decStep) < 0);

endmodule

// File: rtl/frac_divider.sv
`timescale 1ns/1ps
module frac_divider
  import fdiv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int RST_N = 1,
  parameter int RST_M = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             progStrobe,
  input  logic [WIDTH-1:0] progN,
  input  logic [WIDTH-1:0] progM,
  output logic             divClk,
  output logic [WIDTH:0]   accum
);

  fdivStrobe_t strobes;
  logic        accSign;
  logic signed [WIDTH:0] accumInt;

  fdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .progStrobe(progStrobe),
    .progN     (progN),
    .progM     (progM),
    .accSign   (accSign),
    .strobes   (strobes)
  );

  fdiv_datapath #(.WIDTH(WIDTH), .RST_N(RST_N), .RST_M(RST_M)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .progN  (progN),
    .progM  (progM),
    .strobes(strobes),
    .accum  (accumInt),
    .accSign(accSign)
  );

  assign accum  = accumInt;
  assign divClk = accSign;  // R2

endmodule

// File: tb/frac_divider_test.sv
`timescale 1ns/1ps
module frac_divider_test;

  localparam int WIDTH = 8;
  localparam int ACC_W = WIDTH + 1;
  localparam int NVEC  = 9;
  localparam int WARM  = 520;

  // {N, M, windows K, expected high cycles K*N}
  localparam int VEC [NVEC][4] = '{
    '{1,   2,  10, 10},
    '{1,   3,  10, 10},
    '{2,   5,   8, 16},
    '{3,   7,   6, 18},
    '{5,   8,   6, 30},
    '{254, 255, 2, 508},
    '{1,   255, 2, 2},
    '{0,   4,   5, 0},
    '{7,   16,  4, 28}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             progStrobe;
  logic [WIDTH-1:0] progN;
  logic [WIDTH-1:0] progM;
  logic             divClk;
  logic [ACC_W-1:0] accum;

  int  checks = 0;
  int  fails  = 0;
  int  mAcc, mN, mD;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  frac_divider #(.WIDTH(WIDTH), .RST_N(1), .RST_M(2)) uut (
    .clk(clk), .rst(rst), .progStrobe(progStrobe),
    .progN(progN), .progM(progM), .divClk(divClk), .accum(accum)
  );

  function automatic int sacc();
    return int'($signed(accum));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance the model one edge from the current inputs, then compare
  task automatic step(string req);
    int nAcc;
    nAcc = mAcc - ((mAcc < 0) ? mD : mN);
    if (progStrobe && (int'(progN) < int'(progM))) begin
      mN = int'(progN);
      mD = int'(progN) - int'(progM);
    end
    mAcc = nAcc;
    @(posedge clk);
    @(negedge clk);
    check(req, sacc(), mAcc);
    check("R2", int'(divClk), (mAcc < 0) ? 1 : 0);
  endtask

  task automatic prog(int n, int m, string req);
    progN = WIDTH'(n);
    progM = WIDTH'(m);
    progStrobe = 1'b1;
    step(req);
    progStrobe = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 accum", sacc(), 0);
    check("R1 divClk", int'(divClk), 0);
    mAcc = 0; mN = 1; mD = -1;
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    rst = 1'b1; progStrobe = 1'b0; progN = '0; progM = '0;
    @(negedge clk);
    doReset();

    // R1, R4: default 1/2 ratio from reset, counted from the first cycle
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step("R1");
      if (divClk) cnt++;
    end
    check("R4 reset window", cnt, 10);

    // Table of ratios
    for (int v = 0; v < NVEC; v++) begin
      int n, m, lo, hi;
      n = VEC[v][0]; m = VEC[v][1];
      prog(n, m, "R6");
      for (int w = 0; w < WARM; w++) step("R3");
      cnt = 0; lo = 1; hi = 1;
      for (int c = 0; c < VEC[v][2] * m; c++) begin
        step("R3");
        if (divClk) cnt++;
        if (sacc() < -n) lo = 0;
        if (sacc() > m - 1) hi = 0;
      end
      check((n == 0) ? "R9" : "R4", cnt, VEC[v][3]);
      check("R5 low bound", lo, 1);
      check("R5 high bound", hi, 1);
    end

    // R8: illegal pairs leave the 7/16 constants in force
    prog(5, 5, "R8");
    repeat (4) step("R8");
    prog(9, 3, "R8");
    repeat (4) step("R8");
    cnt = 0;
    for (int c = 0; c < 32; c++) begin step("R8"); if (divClk) cnt++; end
    check("R8 ratio kept", cnt, 14);

    // R10: pair changes without the strobe are ignored
    progN = 8'd1; progM = 8'd200;
    cnt = 0;
    for (int c = 0; c < 32; c++) begin step("R10"); if (divClk) cnt++; end
    check("R10 ratio kept", cnt, 14);

    // R7, R6: reprogram mid-run, accumulator carried over
    while (sacc() == 0) step("R7");
    prog(3, 11, "R7");
    check("R7 nonzero kept", (sacc() != 0) ? 1 : 0, 1);
    step("R6");
    for (int w = 0; w < 40; w++) step("R6");
    cnt = 0;
    for (int c = 0; c < 33; c++) begin step("R4"); if (divClk) cnt++; end
    check("R4 3/11", cnt, 9);

    // R1: reset mid-run restores the default constants
    doReset();
    for (int i = 0; i < 6; i++) step("R1");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule